// File: doc/BRIEF.md
# Parallel LCD Write-Cycle Sequencer

This block generates write cycles on an 8080-style parallel bus toward an LCD panel controller. A client offers a data word and a register-select bit (command or pixel/parameter data) on a valid/ready handshake. Once a request is taken, the block drives the register-select and data lines and then runs the active-low chip-select and write strobes through four phases. Each phase has its own programmable length, counted in cycles of the internal video clock that also clocks the block.

The four phases run in a fixed order. The first runs from address valid to chip-select assertion. The second runs from chip-select to the write strobe, the third is the width of the write strobe, and the last runs from strobe release to chip-select release. Each phase lasts its programmed value plus one clock. The timing inputs are sampled when a request is accepted, so software may change them while a cycle is in flight. The handshake reopens in the last hold cycle, which lets a new transfer start straight after chip-select releases.

Top module: `lcd_wr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, bus_cs_n and bus_we_n are 1, busy is 0 and req_ready is 1.
- R2: On a clock edge where req_valid and req_ready are both 1, req_rs and req_data are captured. From the next cycle on, bus_rs and bus_data show the captured values, unchanged, until the next accepted request, including while idle.
- R3: For the first cfg_addr_cs+1 cycles after acceptance, bus_cs_n stays 1 and bus_we_n stays 1 (address phase).
- R4: Next, for cfg_cs_we+1 cycles, bus_cs_n is 0 and bus_we_n is 1.
- R5: Next, for cfg_we_act+1 cycles, bus_we_n is 0 and bus_cs_n is 0.
- R6: Next, for cfg_we_rel+1 cycles, bus_cs_n is 0 and bus_we_n is 1. After that, bus_cs_n returns to 1.
- R7: req_ready is 0 from the cycle after acceptance until the last hold cycle, and 1 in that last hold cycle. A request accepted there starts a new address phase in the very next cycle, with no idle cycle between.
- R8: The four 4-bit timing inputs are sampled only at acceptance. Changing them, or req_data and req_rs, during a transfer does not alter that transfer.
- R9: busy is 1 in every cycle of a transfer, from the first address cycle through the last hold cycle, and 0 otherwise.
- R10: bus_we_n is never 0 while bus_cs_n is 1, and outside a transfer both strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal video clock; all phase lengths count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_cs | input | 4 | Address-to-chip-select phase length minus one |
| cfg_cs_we | input | 4 | Chip-select-to-write phase length minus one |
| cfg_we_act | input | 4 | Write strobe width minus one |
| cfg_we_rel | input | 4 | Write-release-to-chip-select-release length minus one |
| req_valid | input | 1 | A write request is offered |
| req_rs | input | 1 | Register select of the offered request (0 command, 1 data) |
| req_data | input | DATA_W | Data word of the offered request |
| req_ready | output | 1 | Block can accept a request on this edge |
| busy | output | 1 | A write cycle is in progress |
| bus_rs | output | 1 | Register-select line to the panel |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_data | output | DATA_W | Parallel data bus |

## Verification
The bench sweeps all four phase lengths over 0 to 3 and runs every combination. Half the transfers run back-to-back and the rest have an idle gap. It also runs the all-zero, the all-fifteen and the reset-value settings. A design off by one in any phase shows a strobe edge one cycle early or late against the arithmetic trace. A design that reads the timing or data inputs live instead of at acceptance is caught because the bench inverts those inputs in the first cycle of every transfer. A design that needs an idle cycle between chained writes, or that opens ready too early, fails the per-cycle ready and chip-select comparison at the transfer boundary.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

    // width of every phase-length field
    parameter int unsigned PH_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETUP,
        ST_ACTIVE,
        ST_HOLD
    } phase_e;

    typedef struct packed {
        logic [PH_W-1:0] addr_cs;
        logic [PH_W-1:0] cs_we;
        logic [PH_W-1:0] we_act;
        logic [PH_W-1:0] we_rel;
    } phase_cfg_t;

    localparam phase_cfg_t CFG_DEFAULT = '{
        addr_cs: PH_W'(0),
        cs_we:   PH_W'(0),
        we_act:  PH_W'(1),
        we_rel:  PH_W'(0)
    };

    // programmed count (length minus one) of a given phase
    function automatic logic [PH_W-1:0] phase_len(phase_e st, phase_cfg_t c);
        case (st)
            ST_ADDR:   return c.addr_cs;
            ST_SETUP:  return c.cs_we;
            ST_ACTIVE: return c.we_act;
            ST_HOLD:   return c.we_rel;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/lcd_wr_cfg_hold.sv
module lcd_wr_cfg_hold
    import lcd_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  phase_cfg_t cfg_in,
    output phase_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_DEFAULT;
        else if (load)
            cfg_q <= cfg_in;
    end

endmodule

// File: rtl/lcd_wr_data_hold.sv
module lcd_wr_data_hold #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              rs_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              rs_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q   <= 1'b0;
            data_q <= '0;
        end else if (load) begin
            rs_q   <= rs_in;
            data_q <= data_in;
        end
    end

    // R2: captured word changes only on a load
    a_r2_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(data_q) && $stable(rs_q)));

endmodule

// File: rtl/lcd_wr_phase_fsm.sv
module lcd_wr_phase_fsm
    import lcd_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  phase_cfg_t cfg_live,
    input  phase_cfg_t cfg_held,
    output phase_e     state,
    output logic       ready
);

    logic [PH_W-1:0] cnt;
    logic            last;

    assign last  = (cnt == '0);
    assign ready = (state == ST_IDLE) || ((state == ST_HOLD) && last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_ADDR;
                        cnt   <= cfg_live.addr_cs;
                    end
                end
                ST_ADDR, ST_SETUP, ST_ACTIVE: begin
                    if (last) begin
                        state <= phase_e'(state + 3'd1);
                        cnt   <= phase_len(phase_e'(state + 3'd1), cfg_held);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (last && start) begin
                        state <= ST_ADDR;
                        cnt   <= cfg_live.addr_cs;
                    end else if (last) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R3: an accepted request always opens with the address phase
    a_r3_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        start |=> (state == ST_ADDR));

    // R6: hold ending without a new request returns to idle
    a_r6_hold_to_idle: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_HOLD) && last && !start) |=> (state == ST_IDLE));

    // R4: a phase that is not on its last cycle stays put and counts down
    a_r4_phase_countdown: assert property (@(posedge clk) disable iff (rst)
        ((state != ST_IDLE) && !last) |=> ($stable(state) && (cnt == $past(cnt) - 1'b1)));

endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
    import lcd_wr_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   cfg_addr_cs,
    input  logic [PH_W-1:0]   cfg_cs_we,
    input  logic [PH_W-1:0]   cfg_we_act,
    input  logic [PH_W-1:0]   cfg_we_rel,
    input  logic              req_valid,
    input  logic              req_rs,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              busy,
    output logic              bus_rs,
    output logic              bus_cs_n,
    output logic              bus_we_n,
    output logic [DATA_W-1:0] bus_data
);

    phase_cfg_t cfg_live;
    phase_cfg_t cfg_held;
    phase_e     state;
    logic       accept;

    assign cfg_live = '{addr_cs: cfg_addr_cs, cs_we: cfg_cs_we,
                        we_act: cfg_we_act, we_rel: cfg_we_rel};
    assign accept   = req_valid && req_ready;

    lcd_wr_cfg_hold u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .cfg_in (cfg_live),
        .cfg_q  (cfg_held)
    );

    lcd_wr_data_hold #(.DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .rs_in   (req_rs),
        .data_in (req_data),
        .rs_q    (bus_rs),
        .data_q  (bus_data)
    );

    lcd_wr_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .cfg_live (cfg_live),
        .cfg_held (cfg_held),
        .state    (state),
        .ready    (req_ready)
    );

    assign busy     = (state != ST_IDLE);
    assign bus_cs_n = !((state == ST_SETUP) || (state == ST_ACTIVE) || (state == ST_HOLD));
    assign bus_we_n = (state != ST_ACTIVE);

    // R10: write strobe only inside chip select
    a_r10_we_inside_cs: assert property (@(posedge clk) disable iff (rst)
        !bus_we_n |-> !bus_cs_n);

    // R10: both strobes parked when no transfer runs
    a_r10_idle_strobes: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_cs_n && bus_we_n));

    // R5: write strobe falls only after chip select was already low
    a_r5_we_after_cs: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_we_n) |-> $past(!bus_cs_n && bus_we_n));

    // R6: chip select releases only after the write strobe is back high
    a_r6_release_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_cs_n) |-> $past(bus_we_n));

    // R9: an accepted request makes the block busy next cycle
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R2: bus data is frozen within a transfer
    a_r2_data_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(accept)) |-> ($stable(bus_data) && $stable(bus_rs)));

endmodule

// File: tb/lcd_wr_seq_test.sv
module lcd_wr_seq_test;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    cfg_addr_cs = '0, cfg_cs_we = '0, cfg_we_act = '0, cfg_we_rel = '0;
    logic          req_valid = 1'b0;
    logic          req_rs = 1'b0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready, busy, bus_rs, bus_cs_n, bus_we_n;
    logic [DW-1:0] bus_data;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    lcd_wr_seq #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .cfg_addr_cs(cfg_addr_cs), .cfg_cs_we(cfg_cs_we),
        .cfg_we_act(cfg_we_act), .cfg_we_rel(cfg_we_rel),
        .req_valid(req_valid), .req_rs(req_rs), .req_data(req_data),
        .req_ready(req_ready), .busy(busy), .bus_rs(bus_rs),
        .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_data(bus_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge with req_ready high; returns at the falling
    // edge of the last hold cycle.
    task automatic xfer(input int a, input int s, input int w, input int h,
                        input bit rs, input logic [DW-1:0] d);
        int p1, p2, p3, tot;
        p1  = a + 1;
        p2  = p1 + s + 1;
        p3  = p2 + w + 1;
        tot = p3 + h + 1;
        chk(req_ready == 1'b1, "R7 ready before start", int'(req_ready), 1);
        cfg_addr_cs = 4'(a); cfg_cs_we = 4'(s); cfg_we_act = 4'(w); cfg_we_rel = 4'(h);
        req_rs = rs; req_data = d; req_valid = 1'b1;
        for (int k = 1; k <= tot; k++) begin
            @(negedge clk);
            if (k == 1) begin
                // R8: scramble inputs mid-transfer
                req_valid   = 1'b0;
                cfg_addr_cs = ~cfg_addr_cs; cfg_cs_we = ~cfg_cs_we;
                cfg_we_act  = ~cfg_we_act;  cfg_we_rel = ~cfg_we_rel;
                req_rs = ~req_rs; req_data = ~req_data;
            end
            // R3 address phase, R4 setup, R5 strobe, R6 hold
            if (k <= p1) begin
                chk(bus_cs_n == 1'b1, "R3 cs_n in address phase", int'(bus_cs_n), 1);
                chk(bus_we_n == 1'b1, "R3 we_n in address phase", int'(bus_we_n), 1);
            end else if (k <= p2) begin
                chk(bus_cs_n == 1'b0, "R4 cs_n in setup", int'(bus_cs_n), 0);
                chk(bus_we_n == 1'b1, "R4 we_n in setup", int'(bus_we_n), 1);
            end else if (k <= p3) begin
                chk(bus_cs_n == 1'b0, "R5 cs_n in strobe", int'(bus_cs_n), 0);
                chk(bus_we_n == 1'b0, "R5 we_n in strobe", int'(bus_we_n), 0);
            end else begin
                chk(bus_cs_n == 1'b0, "R6 cs_n in hold", int'(bus_cs_n), 0);
                chk(bus_we_n == 1'b1, "R6 we_n in hold", int'(bus_we_n), 1);
            end
            chk(busy == 1'b1, "R9 busy during transfer", int'(busy), 1);
            chk(req_ready == (k == tot), "R7 ready timing", int'(req_ready), int'(k == tot));
            chk(bus_data == d, "R2 R8 bus_data held", int'(bus_data), int'(d));
            chk(bus_rs == rs, "R2 R8 bus_rs held", int'(bus_rs), int'(rs));
        end
        req_valid = 1'b0;
    endtask

    // one idle cycle after a transfer: strobes parked, data kept
    task automatic idle_gap(input bit rs, input logic [DW-1:0] d);
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy low when idle", int'(busy), 0);
        chk(bus_cs_n && bus_we_n, "R10 strobes high when idle",
            int'({bus_cs_n, bus_we_n}), 3);
        chk(req_ready == 1'b1, "R7 ready when idle", int'(req_ready), 1);
        chk(bus_data == d && bus_rs == rs, "R2 data kept while idle",
            int'(bus_data), int'(d));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_cs_n && bus_we_n, "R1 strobes in reset", int'({bus_cs_n, bus_we_n}), 3);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_cs_n && bus_we_n, "R1 strobes after reset", int'({bus_cs_n, bus_we_n}), 3);
        chk(busy == 1'b0 && req_ready == 1'b1, "R1 busy/ready after reset",
            int'({busy, req_ready}), 1);

        // reset-value timing 0,0,1,0
        xfer(0, 0, 1, 0, 1'b0, 16'h002C);
        idle_gap(1'b0, 16'h002C);

        // full sweep over 0..3 per phase; odd entries chain back-to-back
        for (int i = 0; i < 256; i++) begin
            logic [DW-1:0] d;
            d = 16'(i * 16'h0101) ^ 16'hA5C3;
            xfer(i & 3, (i >> 2) & 3, (i >> 4) & 3, (i >> 6) & 3, i[0], d);
            if (!i[0]) idle_gap(i[0], d);
        end
        idle_gap(1'b1, 16'(255 * 16'h0101) ^ 16'hA5C3);

        // extremes
        xfer(15, 15, 15, 15, 1'b1, 16'hFFFF);
        xfer(0, 0, 0, 0, 1'b0, 16'h0000);
        xfer(0, 0, 0, 0, 1'b1, 16'h8001);
        idle_gap(1'b1, 16'h8001);

        // no request: stays idle (R7)
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && bus_cs_n == 1'b1, "R7 no start without valid",
            int'({busy, bus_cs_n}), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule